// File: doc/BRIEF.md
# Single-Port RAM with Selectable Write-Cycle Output

This block is a synchronous single-port memory. One address port serves both reads and writes, on one clock. The data output is always registered, with one cycle of latency. A write-mode parameter sets what the output shows after a cycle in which the port writes:

- the word just written,
- the word that the write displaced, or
- the unchanged previous output.

Cycles without a write show the stored word at the addressed location.

A second parameter picks the read timing:

- **Output-register style:** the array word is captured directly into an output register.
- **Address-register style:** the address is captured and the array is read through combinationally from that registered address.

Both styles behave the same at the ports. They differ only in where the register sits in the read path. All locations and the output are zero from power-up. There is no reset pin.

The block has no state machine. Its only sequencing is the per-edge choice among four cycle kinds:

- **idle:** enable low
- **read:** enable high, write enable low
- **write:** both high
- **power-up:** before the first edge

Top module: `ram_wmode`

## Requirements
- R1: With WR_MODE = 0 (new-data), after an edge where `en` and `we` are both 1, `rdata` equals the `wdata` written on that edge.
- R2: With WR_MODE = 1 (old-data), after an edge where `en` and `we` are both 1, `rdata` equals the word stored at `addr` before that edge, and the array holds `wdata` from that edge on.
- R3: With WR_MODE = 2 (keep), after an edge where `en` and `we` are both 1, `rdata` is unchanged from before the edge.
- R4: After an edge where `en` is 1 and `we` is 0, `rdata` equals the word stored at `addr`.
- R5: After an edge where `en` is 0, `rdata` is unchanged and no location is written, whatever `we`, `addr` and `wdata` are.
- R6: Before the first edge and afterwards, every location reads as zero until written, and `rdata` starts at zero.
- R7: READ_STYLE = 0 (output register) and READ_STYLE = 1 (address register, combinational array read) give identical `rdata` for identical stimulus in every write mode.
- R8: Back-to-back writes to one address leave the last word stored. A read in the cycle directly after a write returns the written word.
- R9: WR_MODE accepts only 0, 1 or 2, and READ_STYLE accepts only 0 or 1. Any other value stops elaboration with an error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| en | input | 1 | Port enable; when 0 the cycle is idle |
| we | input | 1 | Write enable, qualified by `en` |
| addr | input | ADDR_W | Word address for read or write |
| wdata | input | DATA_W | Word to store on a write |
| rdata | output | DATA_W | Registered read data |

## Verification
Assertions inside the top module check on every cycle:

- the write-cycle output policy of the chosen mode (R1, R2, R3),
- the read result against the array word addressed before the edge (R4),
- the output hold on idle cycles (R5).

Other behaviours need the bench's scenarios, which drive one stimulus into six instances and compare each against a shadow model. These are:

- power-up zeros,
- the invisibility of writes attempted with enable low,
- last-write-wins ordering,
- port-level equality of the two read styles.

Rejection of bad parameter values happens only at elaboration.

// File: rtl/ram_wmode_pkg.sv
package ram_wmode_pkg;
    // Write-cycle output policy codes
    localparam int WM_NEW  = 0;
    localparam int WM_OLD  = 1;
    localparam int WM_KEEP = 2;
    localparam int WM_LAST = WM_KEEP;

    // Read timing styles
    localparam int RS_OUTREG  = 0;
    localparam int RS_ADDRREG = 1;
    localparam int RS_LAST    = RS_ADDRREG;
endpackage

// File: rtl/ram_wmode_store.sv
module ram_wmode_store #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] pa_addr,
    output logic [DATA_W-1:0] pa_word,
    input  logic [ADDR_W-1:0] pb_addr,
    output logic [DATA_W-1:0] pb_word
);
    localparam int DEPTH = 1 << ADDR_W;

    // Zero-initialised array (power-up contents)
    logic [DATA_W-1:0] cells [DEPTH] = '{default: '0};

    always_ff @(posedge clk) begin
        if (wr_en) begin
            cells[wr_addr] <= wr_data;
        end
    end

    // Two combinational read taps
    assign pa_word = cells[pa_addr];
    assign pb_word = cells[pb_addr];
endmodule

// File: rtl/ram_wmode_rd_outreg.sv
module ram_wmode_rd_outreg
    import ram_wmode_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int WR_MODE = WM_NEW
) (
    input  logic              clk,
    input  logic              en,
    input  logic              we,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] cur_word,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] q = '0;

    always_ff @(posedge clk) begin
        if (en) begin
            if (!we) begin
                q <= cur_word;
            end else begin
                unique case (WR_MODE)
                    WM_NEW:  q <= wdata;
                    WM_OLD:  q <= cur_word;
                    default: q <= q;
                endcase
            end
        end
    end

    assign rdata = q;
endmodule

// File: rtl/ram_wmode_rd_through.sv
module ram_wmode_rd_through
    import ram_wmode_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int ADDR_W  = 10,
    parameter int WR_MODE = WM_NEW
) (
    input  logic              clk,
    input  logic              en,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] cur_word,
    output logic [ADDR_W-1:0] look_addr,
    input  logic [DATA_W-1:0] look_word,
    output logic [DATA_W-1:0] rdata
);
    logic [ADDR_W-1:0] addr_q = '0;
    logic [DATA_W-1:0] snap   = '0;
    logic              use_snap = 1'b0;

    always_ff @(posedge clk) begin
        if (en) begin
            if (!we || WR_MODE == WM_NEW) begin
                // Array is indexed by the captured address after the edge
                addr_q   <= addr;
                use_snap <= 1'b0;
            end else if (WR_MODE == WM_OLD) begin
                snap     <= cur_word;
                use_snap <= 1'b1;
            end else begin
                snap     <= rdata;
                use_snap <= 1'b1;
            end
        end
    end

    assign look_addr = addr_q;
    assign rdata     = use_snap ? snap : look_word;
endmodule

// File: rtl/ram_wmode.sv
module ram_wmode
    import ram_wmode_pkg::*;
#(
    parameter int DATA_W     = 32,
    parameter int ADDR_W     = 10,
    parameter int WR_MODE    = WM_NEW,
    parameter int READ_STYLE = RS_OUTREG
) (
    input  logic              clk,
    input  logic              en,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    // R9: parameter legality at elaboration
    if (WR_MODE < 0 || WR_MODE > WM_LAST) begin : g_bad_mode
        $error("ram_wmode: WR_MODE must be 0, 1 or 2");
    end
    if (READ_STYLE < 0 || READ_STYLE > RS_LAST) begin : g_bad_style
        $error("ram_wmode: READ_STYLE must be 0 or 1");
    end

    logic              wr_go;
    logic [DATA_W-1:0] cur_word;
    logic [ADDR_W-1:0] look_addr;
    logic [DATA_W-1:0] look_word;

    assign wr_go = en & we;

    ram_wmode_store #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_store (
        .clk     (clk),
        .wr_en   (wr_go),
        .wr_addr (addr),
        .wr_data (wdata),
        .pa_addr (addr),
        .pa_word (cur_word),
        .pb_addr (look_addr),
        .pb_word (look_word)
    );

    if (READ_STYLE == RS_ADDRREG) begin : g_through
        ram_wmode_rd_through #(
            .DATA_W(DATA_W), .ADDR_W(ADDR_W), .WR_MODE(WR_MODE)
        ) u_rd (
            .clk       (clk),
            .en        (en),
            .we        (we),
            .addr      (addr),
            .cur_word  (cur_word),
            .look_addr (look_addr),
            .look_word (look_word),
            .rdata     (rdata)
        );
    end else begin : g_outreg
        logic unused_look;
        assign look_addr   = addr;
        assign unused_look = ^look_word;
        ram_wmode_rd_outreg #(
            .DATA_W(DATA_W), .WR_MODE(WR_MODE)
        ) u_rd (
            .clk      (clk),
            .en       (en),
            .we       (we),
            .wdata    (wdata),
            .cur_word (cur_word),
            .rdata    (rdata)
        );
    end

    // Becomes 1 after the first edge; guards assertions from time zero
    logic live = 1'b0;
    always_ff @(posedge clk) live <= 1'b1;

    if (WR_MODE == WM_NEW) begin : g_chk_new
        a_r1_new_data_out: assert property (@(posedge clk) disable iff (!live)
            wr_go |=> rdata == $past(wdata));
    end
    if (WR_MODE == WM_OLD) begin : g_chk_old
        a_r2_old_data_out: assert property (@(posedge clk) disable iff (!live)
            wr_go |=> rdata == $past(cur_word));
    end
    if (WR_MODE == WM_KEEP) begin : g_chk_keep
        a_r3_output_kept: assert property (@(posedge clk) disable iff (!live)
            wr_go |=> $stable(rdata));
    end

    a_r4_read_word: assert property (@(posedge clk) disable iff (!live)
        (en && !we) |=> rdata == $past(cur_word));

    a_r5_idle_hold: assert property (@(posedge clk) disable iff (!live)
        !en |=> $stable(rdata));
endmodule

// File: tb/ram_wmode_bench.sv
module ram_wmode_bench;
    localparam int DW = 16;
    localparam int AW = 4;
    localparam int NLOC = 1 << AW;
    localparam int NDUT = 6;

    logic clk = 1'b0;
    always #2 clk = ~clk;   // 250 MHz

    logic          en = 1'b0;
    logic          we = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] rd_o [NDUT];

    int n_chk = 0;
    int n_bad = 0;

    // Index = mode*2 + style. R9: modes 0,1,2 and styles 0,1 are all legal encodings.
    for (genvar m = 0; m < 3; m++) begin : g_m
        for (genvar s = 0; s < 2; s++) begin : g_s
            ram_wmode #(.DATA_W(DW), .ADDR_W(AW), .WR_MODE(m), .READ_STYLE(s)) u_ram_wmode (
                .clk(clk), .en(en), .we(we), .addr(addr), .wdata(wdata), .rdata(rd_o[m*2+s])
            );
        end
    end

    // Shadow model
    logic [DW-1:0] sh [NLOC];
    logic [DW-1:0] ex [3];

    typedef struct packed {
        logic          v_en;
        logic          v_we;
        logic [AW-1:0] v_a;
        logic [DW-1:0] v_d;
    } vec_t;

    localparam vec_t VT [16] = '{
        '{1'b1, 1'b1, 4'd3,  16'hA001},
        '{1'b1, 1'b0, 4'd3,  16'h0000},
        '{1'b1, 1'b1, 4'd3,  16'hB002},  // overwrite: old-data mode shows A001
        '{1'b1, 1'b1, 4'd3,  16'hC003},  // back-to-back same address
        '{1'b1, 1'b0, 4'd3,  16'h0000},  // read right after write
        '{1'b0, 1'b1, 4'd3,  16'hDEAD},  // disabled write
        '{1'b1, 1'b0, 4'd3,  16'h0000},
        '{1'b1, 1'b1, 4'd7,  16'h7777},
        '{1'b0, 1'b0, 4'd9,  16'h1234},
        '{1'b1, 1'b0, 4'd9,  16'h0000},  // never written
        '{1'b1, 1'b1, 4'd0,  16'hFFFF},
        '{1'b1, 1'b1, 4'd15, 16'h5A5A},
        '{1'b1, 1'b0, 4'd0,  16'h0000},
        '{1'b1, 1'b1, 4'd15, 16'hA5A5},
        '{1'b1, 1'b0, 4'd7,  16'h0000},
        '{1'b1, 1'b0, 4'd15, 16'h0000}
    };

    task automatic chk(input int idx, input logic [DW-1:0] want, input string req);
        n_chk++;
        if (rd_o[idx] !== want) begin
            n_bad++;
            $display("FAIL %s dut%0d (mode %0d style %0d): got %h expected %h",
                     req, idx, idx / 2, idx % 2, rd_o[idx], want);
        end
    endtask

    task automatic step(input logic e, input logic w, input logic [AW-1:0] a,
                        input logic [DW-1:0] d);
        string tag;
        @(negedge clk);
        en = e; we = w; addr = a; wdata = d;
        @(posedge clk);
        for (int m = 0; m < 3; m++) begin
            if (e) begin
                if (!w) ex[m] = sh[a];
                else if (m == 0) ex[m] = d;
                else if (m == 1) ex[m] = sh[a];
            end
        end
        if (e && w) sh[a] = d;
        #1;
        for (int i = 0; i < NDUT; i++) begin
            if (!e) tag = "R5";
            else if (!w) tag = "R4/R8";
            else if (i / 2 == 0) tag = "R1";
            else if (i / 2 == 1) tag = "R2";
            else tag = "R3";
            if (i % 2 == 1) tag = {tag, "+R7"};
            chk(i, ex[i / 2], tag);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    endtask

    initial begin
        #(4 * 150000);
        n_bad++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        logic [15:0] lf;
        for (int i = 0; i < NLOC; i++) sh[i] = '0;
        for (int m = 0; m < 3; m++) ex[m] = '0;

        // R6: outputs zero before the first edge
        #1;
        for (int i = 0; i < NDUT; i++) chk(i, '0, "R6 power-up output");

        // Table walk
        for (int k = 0; k < 16; k++) step(VT[k].v_en, VT[k].v_we, VT[k].v_a, VT[k].v_d);

        // R6: untouched locations still read zero
        step(1'b1, 1'b0, 4'd12, 16'h0);
        for (int i = 0; i < NDUT; i++) chk(i, '0, "R6 unwritten location");

        // R5: write attempted with en low leaves the location and output alone
        step(1'b1, 1'b1, 4'd5, 16'h1111);
        step(1'b0, 1'b1, 4'd5, 16'h2222);
        step(1'b1, 1'b0, 4'd5, 16'h0);
        for (int i = 0; i < NDUT; i++) chk(i, 16'h1111, "R5 disabled write ignored");

        // R8: last of back-to-back writes wins, read right after
        step(1'b1, 1'b1, 4'd6, 16'h0101);
        step(1'b1, 1'b1, 4'd6, 16'h0202);
        step(1'b1, 1'b1, 4'd6, 16'h0303);
        step(1'b1, 1'b0, 4'd6, 16'h0);
        for (int i = 0; i < NDUT; i++) chk(i, 16'h0303, "R8 last write wins");

        // R2: old-data mode shows displaced word on a write
        step(1'b1, 1'b1, 4'd6, 16'h0404);
        chk(2, 16'h0303, "R2 displaced word");
        chk(3, 16'h0303, "R2+R7 displaced word");

        // Pseudo-random traffic
        lf = 16'hACE1;
        for (int k = 0; k < 400; k++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            step(lf[0] | lf[1], lf[2], lf[7:4], lf ^ 16'h3C3C);
        end

        summary();
        $finish;
    end
endmodule